// File: doc/BRIEF.md
# Periodic Coupling-Noise Canceller

This block sits in the transmit data path just ahead of a time-interleaved DAC. On the line it drives, a static disturbance repeats every `PERIOD` symbols, locked to the reference clock. The block holds one signed correction value for each symbol position in that period. It adds that value to the outgoing symbol at that position and clamps the sum to the DAC code range. Each clock cycle carries one word of `LANES` symbols, so one period takes `PERIOD/LANES` cycles. Lane `k` of the word at group `g` sits at position `g*LANES + k`.

The corrections are learned from the receiver's decisions. The receiver reports a signed error sample together with the position it belongs to. While adaptation is enabled, the entry for that position steps by one count in the direction opposite to the sign of the error. Over time each entry settles at a constant minus the coupling seen at its position. A sync input realigns the internal position counter to the reference clock. A read port returns any single table entry.

Top module: `txcpl_cancel`

## Requirements
- R1: A synchronous active-high reset clears every table entry to 0, sets the position counter to group 0, and drives `tx_data_o`, `tx_pos_o` and `tbl_data_o` to 0.
- R2: Each lane `k` of `tx_data_o` equals, one cycle after the input word, the unsigned input symbol of lane `k` plus the table entry for position `base + k`, where `base` is the base position of that input word.
- R3: The sum in R2 is clamped to the range 0 to 2^SYM_W-1 (0 to 255 by default).
- R4: Without sync, the base position advances by `LANES` each cycle and wraps from `PERIOD-LANES` to 0. `tx_pos_o` reports, alongside each output word, the base position of that word.
- R5: A word presented with `sync_i` high takes base position 0, and the following word takes base position `LANES`.
- R6: When `adapt_en_i` and `err_valid_i` are both high and `err_i` (two's complement) is nonzero, the entry at `err_pos_i` changes by exactly one: minus one for a positive error, plus one for a negative error.
- R7: A zero error, a low `err_valid_i`, or a low `adapt_en_i` leaves every table entry unchanged.
- R8: Entries are signed `CORR_W`-bit values (-32 to +31 by default) that saturate: a step beyond either limit leaves the entry at that limit.
- R9: An update takes effect at the clock edge that ends the cycle in which the error is accepted. A symbol at the same position in that same cycle still uses the old value. The next pass through that position uses the new value.
- R10: `tbl_data_o` returns, one cycle after `tbl_addr_i`, the signed entry at that position as it stood before any update in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Treat the current word as base position 0 |
| tx_data_i | input | LANES*SYM_W | Transmit word; lane k in bits [k*SYM_W +: SYM_W] |
| tx_data_o | output | LANES*SYM_W | Corrected, clamped transmit word (registered) |
| tx_pos_o | output | $clog2(PERIOD) | Base position of the word on tx_data_o |
| adapt_en_i | input | 1 | Allow table adaptation |
| err_valid_i | input | 1 | Error sample strobe |
| err_i | input | ERR_W | Signed receiver error sample |
| err_pos_i | input | $clog2(PERIOD) | Period position that the error sample refers to |
| tbl_addr_i | input | $clog2(PERIOD) | Table read position |
| tbl_data_o | output | CORR_W | Signed table entry (registered) |

## Verification
The bench builds the block with four lanes, a 16-symbol period, 6-bit symbols, 4-bit corrections and 5-bit errors. With that small configuration every input code can be swept against every position, and both clamp limits of the output are reached. The entry limits of -8 and +7 are also reached within a few dozen updates. A reference table kept in the bench is compared with the registered outputs and with the read port every cycle. Runs of random updates, updates aimed at the position being transmitted in the same cycle, and mid-period sync pulses are compared in the same way.

// File: rtl/txcpl_pkg.sv
package txcpl_pkg;

  // Direction of a single correction step.
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/txcpl_phase_ctr.sv
// Group counter: one group of LANES symbols per cycle, GROUPS groups per period.
module txcpl_phase_ctr #(
  parameter int GROUPS = 4,
  parameter int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_i,
  output logic [GW-1:0] grp_o
);

  localparam logic [GW-1:0] LAST  = GW'(GROUPS - 1);
  localparam logic [GW-1:0] AFTER0 = (GROUPS > 1) ? GW'(1) : GW'(0);

  logic [GW-1:0] grp_q;

  // Effective group of the word in flight this cycle.
  assign grp_o = sync_i ? '0 : grp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_q <= '0;
    end else if (grp_o == LAST) begin
      grp_q <= '0;
    end else begin
      grp_q <= grp_o + GW'(1);
    end
  end

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && grp_q == LAST) |=> grp_q == '0); // R4

  AST_POS_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (!sync_i && grp_q != LAST) |=> grp_q == $past(grp_q) + GW'(1)); // R4

  AST_SYNC_ALIGN: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> grp_q == AFTER0); // R5

endmodule

// File: rtl/txcpl_bank.sv
// One lane's slice of the correction table: DEPTH entries, one write port
// with saturating read-modify-write, and two asynchronous read ports.
module txcpl_bank
  import txcpl_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int AW     = 2,
  parameter int CORR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [AW-1:0]     wa_i,
  input  step_e             dir_i,
  input  logic [AW-1:0]     ra_i,
  input  logic [AW-1:0]     rb_i,
  output logic [CORR_W-1:0] ra_data_o,
  output logic [CORR_W-1:0] rb_data_o
);

  localparam logic [CORR_W-1:0] MAXV = {1'b0, {(CORR_W-1){1'b1}}};
  localparam logic [CORR_W-1:0] MINV = {1'b1, {(CORR_W-1){1'b0}}};

  logic [DEPTH-1:0][CORR_W-1:0] mem_q;
  logic [CORR_W-1:0]            cur;
  logic [CORR_W-1:0]            nxt;

  assign cur       = mem_q[wa_i];
  assign ra_data_o = mem_q[ra_i];
  assign rb_data_o = mem_q[rb_i];

  always_comb begin
    nxt = cur;
    case (dir_i)
      STEP_UP:   if (cur != MAXV) nxt = cur + CORR_W'(1);
      STEP_DOWN: if (cur != MINV) nxt = cur - CORR_W'(1);
      default:   nxt = cur;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
    end else if (we_i) begin
      mem_q[wa_i] <= nxt;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mem_q)); // R7

  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (we_i && dir_i == STEP_UP && cur != MAXV)
      |=> mem_q[$past(wa_i)] == $past(cur) + CORR_W'(1)); // R6

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (we_i && dir_i == STEP_DOWN && cur != MINV)
      |=> mem_q[$past(wa_i)] == $past(cur) - CORR_W'(1)); // R6

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
    (we_i && dir_i == STEP_UP && cur == MAXV) |=> mem_q[$past(wa_i)] == MAXV); // R8

  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst)
    (we_i && dir_i == STEP_DOWN && cur == MINV) |=> mem_q[$past(wa_i)] == MINV); // R8

endmodule

// File: rtl/txcpl_lane_add.sv
// Adds a signed correction to one unsigned symbol and clamps to the code range.
module txcpl_lane_add #(
  parameter int SYM_W  = 8,
  parameter int CORR_W = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SYM_W-1:0]         sym_i,
  input  logic signed [CORR_W-1:0] corr_i,
  output logic [SYM_W-1:0]         sym_o
);

  localparam int XW = SYM_W + 2;
  localparam logic signed [XW-1:0] TOP = XW'((1 << SYM_W) - 1);

  logic signed [XW-1:0] sum;
  logic [SYM_W-1:0]     clamped;

  assign sum = $signed({2'b00, sym_i}) + XW'(corr_i);

  always_comb begin
    if (sum < 0) begin
      clamped = '0;
    end else if (sum > TOP) begin
      clamped = '1;
    end else begin
      clamped = sum[SYM_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sym_o <= '0;
    end else begin
      sym_o <= clamped;
    end
  end

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (corr_i == '0) |=> sym_o == $past(sym_i)); // R2

endmodule

// File: rtl/txcpl_cancel.sv
// Periodic coupling-noise canceller. LANES must be a power of two and
// PERIOD a power-of-two multiple of LANES with at least two groups.
module txcpl_cancel
  import txcpl_pkg::*;
#(
  parameter int LANES  = 8,
  parameter int SYM_W  = 8,
  parameter int PERIOD = 32,
  parameter int CORR_W = 6,
  parameter int ERR_W  = 8,
  parameter int PW     = $clog2(PERIOD)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sync_i,
  input  logic [LANES*SYM_W-1:0] tx_data_i,
  output logic [LANES*SYM_W-1:0] tx_data_o,
  output logic [PW-1:0]          tx_pos_o,
  input  logic                   adapt_en_i,
  input  logic                   err_valid_i,
  input  logic [ERR_W-1:0]       err_i,
  input  logic [PW-1:0]          err_pos_i,
  input  logic [PW-1:0]          tbl_addr_i,
  output logic [CORR_W-1:0]      tbl_data_o
);

  localparam int GROUPS = PERIOD / LANES;
  localparam int LB     = $clog2(LANES);
  localparam int GW     = PW - LB;

  // ---------------- position counter ----------------
  logic [GW-1:0] grp;

  txcpl_phase_ctr #(.GROUPS(GROUPS), .GW(GW)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .sync_i (sync_i),
    .grp_o  (grp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pos_o <= '0;
    end else begin
      tx_pos_o <= {grp, {LB{1'b0}}};
    end
  end

  // ---------------- adaptation decision ----------------
  step_e         dir;
  logic          upd;
  logic [LB-1:0] err_lane;
  logic [GW-1:0] err_grp;

  always_comb begin
    if (adapt_en_i && err_valid_i && (err_i != '0)) begin
      dir = err_i[ERR_W-1] ? STEP_UP : STEP_DOWN;
    end else begin
      dir = STEP_HOLD;
    end
  end

  assign upd      = (dir != STEP_HOLD);
  assign err_lane = err_pos_i[LB-1:0];
  assign err_grp  = err_pos_i[PW-1:LB];

  // ---------------- per-lane table slice and adder ----------------
  logic [CORR_W-1:0] corr_rd [LANES];
  logic [CORR_W-1:0] dbg_rd  [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic we_k;
    assign we_k = upd && (err_lane == LB'(k));

    txcpl_bank #(.DEPTH(GROUPS), .AW(GW), .CORR_W(CORR_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .we_i      (we_k),
      .wa_i      (err_grp),
      .dir_i     (dir),
      .ra_i      (grp),
      .rb_i      (tbl_addr_i[PW-1:LB]),
      .ra_data_o (corr_rd[k]),
      .rb_data_o (dbg_rd[k])
    );

    txcpl_lane_add #(.SYM_W(SYM_W), .CORR_W(CORR_W)) u_add (
      .clk    (clk),
      .rst    (rst),
      .sym_i  (tx_data_i[k*SYM_W +: SYM_W]),
      .corr_i (corr_rd[k]),
      .sym_o  (tx_data_o[k*SYM_W +: SYM_W])
    );
  end

  // ---------------- table read port ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_data_o <= '0;
    end else begin
      tbl_data_o <= dbg_rd[tbl_addr_i[LB-1:0]];
    end
  end

  AST_POS_REPORT: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> tx_pos_o == '0); // R5

  AST_NO_ADAPT_STILL: assert property (@(posedge clk) disable iff (rst)
    (!adapt_en_i && tbl_addr_i == $past(tbl_addr_i) && !$past(upd))
      |=> tbl_data_o == $past(tbl_data_o)); // R7

endmodule

// File: tb/tb_txcpl_cancel.sv
module tb_txcpl_cancel;

  localparam int L  = 4;
  localparam int SW = 6;
  localparam int P  = 16;
  localparam int CW = 4;
  localparam int EW = 5;
  localparam int G  = P / L;
  localparam int PW = 4;
  localparam int EMAX = (1 << (CW - 1)) - 1;
  localparam int EMIN = -(1 << (CW - 1));
  localparam int SMAX = (1 << SW) - 1;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            sync_i = 1'b0;
  logic [L*SW-1:0] tx_in = '0;
  logic [L*SW-1:0] tx_out;
  logic [PW-1:0]   tx_pos;
  logic            adapt = 1'b0;
  logic            evld = 1'b0;
  logic [EW-1:0]   err = '0;
  logic [PW-1:0]   epos = '0;
  logic [PW-1:0]   taddr = '0;
  logic [CW-1:0]   tdata;

  always #10 clk = ~clk;

  txcpl_cancel #(.LANES(L), .SYM_W(SW), .PERIOD(P), .CORR_W(CW), .ERR_W(EW)) dut (
    .clk         (clk),
    .rst         (rst),
    .sync_i      (sync_i),
    .tx_data_i   (tx_in),
    .tx_data_o   (tx_out),
    .tx_pos_o    (tx_pos),
    .adapt_en_i  (adapt),
    .err_valid_i (evld),
    .err_i       (err),
    .err_pos_i   (epos),
    .tbl_addr_i  (taddr),
    .tbl_data_o  (tdata)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int tbl [P];   // reference table built from the requirements
  int gm = 0;    // reference group counter

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Caller is just past a falling edge; drive, then compare at the next one.
  task automatic cyc(bit sy, logic [L*SW-1:0] tx, bit ad, bit ev, int e, int ep,
                     int ra, string tag);
    int ge;
    int expo [L];
    int exprd;
    int v;
    sync_i = sy; tx_in = tx; adapt = ad; evld = ev;
    err = EW'(e); epos = PW'(ep); taddr = PW'(ra);
    ge = sy ? 0 : gm;
    for (int k = 0; k < L; k++) begin
      v = int'(tx[k*SW +: SW]) + tbl[ge*L + k];
      if (v < 0) v = 0;
      if (v > SMAX) v = SMAX;
      expo[k] = v;
    end
    exprd = tbl[ra];
    if (ad && ev && e != 0) begin
      if (e > 0 && tbl[ep] > EMIN) tbl[ep] = tbl[ep] - 1;
      if (e < 0 && tbl[ep] < EMAX) tbl[ep] = tbl[ep] + 1;
    end
    gm = (ge + 1) % G;
    @(negedge clk);
    for (int k = 0; k < L; k++)
      chk(int'(tx_out[k*SW +: SW]) == expo[k], $sformatf("%s lane%0d", tag, k),
          int'(tx_out[k*SW +: SW]), expo[k]);
    chk(int'(tx_pos) == ge*L, sy ? "R5 position" : "R4 position", int'(tx_pos), ge*L);
    chk(int'($signed(tdata)) == exprd, $sformatf("R10 read (%s)", tag),
        int'($signed(tdata)), exprd);
  endtask

  function automatic logic [L*SW-1:0] rnd_word();
    logic [L*SW-1:0] w;
    for (int k = 0; k < L; k++) w[k*SW +: SW] = SW'($urandom_range(SMAX, 0));
    return w;
  endfunction

  function automatic logic [L*SW-1:0] flat_word(int v);
    logic [L*SW-1:0] w;
    for (int k = 0; k < L; k++) w[k*SW +: SW] = SW'(v);
    return w;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < P; i++) tbl[i] = 0;
    tx_in = flat_word(SMAX);
    repeat (3) @(negedge clk);
    // R1: outputs held at zero while reset is asserted
    chk(tx_out == '0, "R1 tx_data_o in reset", int'(tx_out), 0);
    chk(tx_pos == '0, "R1 tx_pos_o in reset", int'(tx_pos), 0);
    chk(tdata == '0, "R1 tbl_data_o in reset", int'(tdata), 0);
    rst = 1'b0;

    // R1: every entry reads zero after reset; outputs pass through unchanged
    for (int a = 0; a < P; a++) cyc(1'b0, rnd_word(), 1'b0, 1'b0, 0, 0, a, "R1");

    // R6: random decision-directed updates at random positions
    for (int i = 0; i < 200; i++)
      cyc(1'b0, rnd_word(), 1'b1, 1'b1, $urandom_range(30, 0) - 15,
          $urandom_range(P - 1, 0), i % P, "R6");

    // R9: update aimed at a position being transmitted in the same cycle
    for (int i = 0; i < 3 * G; i++)
      cyc(1'b0, rnd_word(), 1'b1, 1'b1, (i % 2 == 0) ? -3 : 4,
          gm * L + (i % L), gm * L + (i % L), "R9");

    // R8: drive one entry to the bottom and another to the top, then beyond
    for (int i = 0; i < 20; i++) cyc(1'b0, rnd_word(), 1'b1, 1'b1, 7, 5, 5, "R8");
    for (int i = 0; i < 20; i++) cyc(1'b0, rnd_word(), 1'b1, 1'b1, -9, 10, 10, "R8");
    chk(tbl[5] == EMIN && tbl[10] == EMAX, "R8 model limits", tbl[5], EMIN);

    // R7: zero error, no strobe, or adaptation off: nothing may move
    for (int i = 0; i < 48; i++) begin
      case (i % 3)
        0:       cyc(1'b0, rnd_word(), 1'b1, 1'b1, 0, i % P, i % P, "R7");
        1:       cyc(1'b0, rnd_word(), 1'b1, 1'b0, -6, i % P, i % P, "R7");
        default: cyc(1'b0, rnd_word(), 1'b0, 1'b1, 6, i % P, i % P, "R7");
      endcase
    end

    // R3: every code on every position, reaching both clamp limits
    for (int v = 0; v <= SMAX; v++)
      for (int g = 0; g < G; g++)
        cyc(1'b0, flat_word(v), 1'b0, 1'b0, 0, 0, (v + g) % P, "R3");

    // R2: plain correction with mixed lane values
    for (int i = 0; i < 64; i++) cyc(1'b0, rnd_word(), 1'b0, 1'b0, 0, 0, i % P, "R2");

    // R5: sync pulses at every phase of the period
    for (int i = 0; i < 24; i++)
      cyc((i % 3) == 1, rnd_word(), 1'b1, 1'b1, (i % 2) ? 2 : -2, i % P, i % P, "R5");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule